// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Controller

This block sits between a synchronous host port and an asynchronous, byte-wide non-volatile memory with a 21-bit address and an 8-bit data bus. The memory has active-low chip enable, write enable and output enable. The host issues one byte read or one byte write per request. The controller turns each request into the memory's control waveforms. All timing is counted in clock cycles, and each interval is rounded up from a time parameter in picoseconds.

Reads hold chip enable and output enable low for a full access window before the data bus is sampled. A read that follows another read directly keeps both strobes low and changes only the address. Writes are terminated by write enable rising while chip enable is still low. When the memory may still be driving the bus from an open read, the controller waits a turnaround interval after write enable falls before it drives data. The data bus is split into an output, a drive enable and an input, so that the tri-state buffer sits outside this block. A separate power and sleep sequencer grants access through a single `allow_i` input.

State machine: states `ST_OFF` (deselected), `ST_RD_ACC` (access window), `ST_RD_OPEN` (read done, strobes still low), `ST_WR_TURN` (write enable low, bus floating), `ST_WR_DRIVE` (write enable low, data driven) and `ST_WR_REC` (write enable high, data held).

Transitions:
- `ST_OFF` goes to `ST_RD_ACC` or `ST_WR_DRIVE` on an accepted request.
- `ST_RD_ACC` goes to `ST_RD_OPEN` when the cycle time has elapsed.
- `ST_RD_OPEN` goes to `ST_RD_ACC` on a read, to `ST_WR_TURN` on a write, and otherwise to `ST_OFF`.
- `ST_WR_TURN` goes to `ST_WR_DRIVE` when the turnaround has elapsed.
- `ST_WR_DRIVE` goes to `ST_WR_REC` when the pulse width has elapsed.
- `ST_WR_REC` goes to `ST_OFF`.

Top module: `amem_ctrl`

## Requirements
- R1: While reset is asserted and after it, the controller is deselected. Chip enable, write enable and output enable are high (1), the drive enable is 0, and read-valid is 0.
- R2: `host_rdy_o` is 1 only when `allow_i` is 1 and no transfer is in progress. A request presented while ready is 0 has no effect on the memory or on the host outputs.
- R3: A read drives chip enable and output enable low with write enable high. `host_rdata_o` then returns the byte stored at the requested address, together with a one-cycle `host_rvalid_o` pulse.
- R4: Read data is sampled only at the end of the ACC_CYC-th consecutive cycle with chip enable and output enable low and the address unchanged. With the default parameters ACC_CYC is 5.
- R5: During back-to-back reads, the address changes only after it has been held for at least RC_CYC cycles with both strobes low.
- R6: A write drives chip enable and write enable low and places the host byte on the bus. The byte is still driven in the cycle in which write enable rises, so it is stored at the requested address.
- R7: A write that follows an open read keeps the drive enable at 0 for the first TURN_CYC cycles of write enable low. With the default parameters TURN_CYC is 2. A write issued from the deselected state drives data in its first write-enable-low cycle.
- R8: Write enable stays low for at least WP_CYC cycles after data is first driven, and rises while chip enable is still low. With the default parameters WP_CYC is 4.
- R9: The drive enable is never 1 while output enable is low, and output enable is high whenever write enable is low.
- R10: After a write, the block deselects and releases the drive enable before output enable falls for any later read.
- R11: When `allow_i` falls, a transfer in progress completes. The controller then deselects, with chip enable high, and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| allow_i | input | 1 | Access grant from the power/sleep sequencer |
| host_req_i | input | 1 | Host request, taken when ready is 1 |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 21 | Byte address |
| host_wdata_i | input | 8 | Write byte |
| host_rdy_o | output | 1 | Controller can accept a request |
| host_rdata_o | output | 8 | Read byte |
| host_rvalid_o | output | 1 | One-cycle strobe for read data |
| mem_addr_o | output | 21 | Memory address lines |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable of the data bus |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The memory model returns a poison byte until the final cycle of the access window. A controller that samples one cycle early therefore returns wrong data. The bench times every write pulse and compares it with the expected shape: a write directly after a read must show exactly two undriven cycles, and a write from deselect must show none. A controller without turnaround, or one that turned around every time, shows the wrong shape. Requests issued while ready is low, either during a transfer or with access withheld, must leave the memory unchanged; a controller that latched them would add writes or corrupt a later read. Back-to-back reads at the top and bottom addresses, and a withdrawal of access during a read, show whether the strobes stay low across reads and whether the block deselects afterwards.

// File: rtl/amem_pkg.sv
package amem_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RD_ACC,
        ST_RD_OPEN,
        ST_WR_TURN,
        ST_WR_DRIVE,
        ST_WR_REC
    } amem_state_e;

    // Whole clock cycles needed to cover t_ps, rounded up.
    function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/amem_cyc_cnt.sv
// Cycle counter: cleared on state entry, saturates at all-ones.
module amem_cyc_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != {CW{1'b1}}) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/amem_xfer_reg.sv
// Holds the address and write byte of the accepted request.
module amem_xfer_reg #(
    parameter int unsigned AW = 21,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            data_o <= '0;
        end else if (ld_i) begin
            addr_o <= addr_i;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/amem_rd_cap.sv
// Samples the memory bus at the end of the access window and flags it.
module amem_rd_cap #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o,
    output logic          vld_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o   <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= cap_i;
            if (cap_i) begin
                q_o <= d_i;
            end
        end
    end
endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
    import amem_pkg::*;
#(
    parameter int unsigned AW        = 21,
    parameter int unsigned DW        = 8,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_ACC_PS  = 45000,
    parameter int unsigned T_RC_PS   = 45000,
    parameter int unsigned T_TURN_PS = 15000,
    parameter int unsigned T_WP_PS   = 35000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          allow_i,
    input  logic          host_req_i,
    input  logic          host_we_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic          host_rdy_o,
    output logic [DW-1:0] host_rdata_o,
    output logic          host_rvalid_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_ce_n_o,
    output logic          mem_we_n_o,
    output logic          mem_oe_n_o,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe_o,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int unsigned ACC_CYC  = at_least(cyc_ceil(T_ACC_PS, CLK_PS), 1);
    localparam int unsigned RC_CYC   = at_least(cyc_ceil(T_RC_PS, CLK_PS), ACC_CYC);
    localparam int unsigned TURN_CYC = at_least(cyc_ceil(T_TURN_PS, CLK_PS), 1);
    localparam int unsigned WP_CYC   = at_least(cyc_ceil(T_WP_PS, CLK_PS), 1);
    localparam int unsigned MAX_CYC  = at_least(at_least(RC_CYC, TURN_CYC), WP_CYC);
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] ACC_LAST  = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] RC_LAST   = CW'(RC_CYC - 1);
    localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC - 1);
    localparam logic [CW-1:0] WP_LAST   = CW'(WP_CYC - 1);

    amem_state_e   state_q, state_d;
    logic [CW-1:0] cnt;
    logic          accept;
    logic          capture;

    // Ready only in states that can take a new request.
    always_comb begin
        host_rdy_o = allow_i && ((state_q == ST_OFF) || (state_q == ST_RD_OPEN));
    end

    assign accept  = host_req_i && host_rdy_o;
    assign capture = (state_q == ST_RD_ACC) && (cnt == ACC_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (accept) begin
                    state_d = host_we_i ? ST_WR_DRIVE : ST_RD_ACC;
                end
            end
            ST_RD_ACC: begin
                if (cnt == RC_LAST) begin
                    state_d = ST_RD_OPEN;
                end
            end
            ST_RD_OPEN: begin
                if (accept) begin
                    state_d = host_we_i ? ST_WR_TURN : ST_RD_ACC;
                end else begin
                    state_d = ST_OFF;
                end
            end
            ST_WR_TURN: begin
                if (cnt == TURN_LAST) begin
                    state_d = ST_WR_DRIVE;
                end
            end
            ST_WR_DRIVE: begin
                if (cnt == WP_LAST) begin
                    state_d = ST_WR_REC;
                end
            end
            ST_WR_REC: begin
                state_d = ST_OFF;
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // Output decode
    always_comb begin
        mem_ce_n_o  = 1'b1;
        mem_we_n_o  = 1'b1;
        mem_oe_n_o  = 1'b1;
        mem_dq_oe_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_RD_ACC, ST_RD_OPEN: begin
                mem_ce_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
            end
            ST_WR_TURN: begin
                mem_ce_n_o = 1'b0;
                mem_we_n_o = 1'b0;
            end
            ST_WR_DRIVE: begin
                mem_ce_n_o  = 1'b0;
                mem_we_n_o  = 1'b0;
                mem_dq_oe_o = 1'b1;
            end
            ST_WR_REC: begin
                mem_ce_n_o  = 1'b0;
                mem_dq_oe_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    amem_cyc_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .cnt_o (cnt)
    );

    amem_xfer_reg #(.AW(AW), .DW(DW)) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (accept),
        .addr_i (host_addr_i),
        .data_i (host_wdata_i),
        .addr_o (mem_addr_o),
        .data_o (mem_dq_o)
    );

    amem_rd_cap #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (capture),
        .d_i   (mem_dq_i),
        .q_o   (host_rdata_o),
        .vld_o (host_rvalid_o)
    );

endmodule

// File: rtl/amem_ctrl_chk.sv
module amem_ctrl_chk #(
    parameter int unsigned AW       = 21,
    parameter int unsigned ACC_CYC  = 5,
    parameter int unsigned RC_CYC   = 5,
    parameter int unsigned TURN_CYC = 2,
    parameter int unsigned WP_CYC   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          allow_i,
    input logic          host_rdy_o,
    input logic          host_rvalid_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ce_n_o,
    input logic          mem_we_n_o,
    input logic          mem_oe_n_o,
    input logic          mem_dq_oe_o
);
    logic [15:0]   rd_run;
    logic [15:0]   we_run;
    logic [15:0]   drv_run;
    logic [AW-1:0] addr_q;
    logic          from_rd;
    logic          rd_on;

    assign rd_on = !mem_ce_n_o && !mem_oe_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_run  <= '0;
            we_run  <= '0;
            drv_run <= '0;
            addr_q  <= '0;
            from_rd <= 1'b0;
        end else begin
            addr_q <= mem_addr_o;
            if (!rd_on)                  rd_run <= '0;
            else if (mem_addr_o != addr_q) rd_run <= 16'd1;
            else if (rd_run != 16'hFFFF)   rd_run <= rd_run + 16'd1;
            if (mem_we_n_o)              we_run <= '0;
            else if (we_run != 16'hFFFF) we_run <= we_run + 16'd1;
            if (mem_we_n_o || !mem_dq_oe_o) drv_run <= '0;
            else if (drv_run != 16'hFFFF)   drv_run <= drv_run + 16'd1;
            if (mem_we_n_o) from_rd <= !mem_oe_n_o;
        end
    end

    assert_rdy_needs_allow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !allow_i |-> !host_rdy_o);
    assert_no_rdy_while_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !host_rdy_o);
    assert_access_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid_o |-> (rd_run >= 16'(ACC_CYC)));
    assert_read_cycle_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && $past(rd_on) && (mem_addr_o != $past(mem_addr_o))) |-> (rd_run >= 16'(RC_CYC)));
    assert_write_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !mem_ce_n_o);
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && mem_dq_oe_o && from_rd) |-> (we_run >= 16'(TURN_CYC)));
    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (!mem_ce_n_o && (drv_run >= 16'(WP_CYC))));
    assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o);
    assert_oe_off_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o);
    assert_release_before_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> ($past(!mem_dq_oe_o) && !mem_dq_oe_o));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !host_rvalid_o));

endmodule

bind amem_ctrl amem_ctrl_chk #(
    .AW       (AW),
    .ACC_CYC  (ACC_CYC),
    .RC_CYC   (RC_CYC),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .allow_i       (allow_i),
    .host_rdy_o    (host_rdy_o),
    .host_rvalid_o (host_rvalid_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ce_n_o    (mem_ce_n_o),
    .mem_we_n_o    (mem_we_n_o),
    .mem_oe_n_o    (mem_oe_n_o),
    .mem_dq_oe_o   (mem_dq_oe_o)
);

// File: tb/amem_ctrl_test.sv
module amem_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS     = 10000;
    localparam int ACC_CYC    = 5;   // ceil(45000/10000)
    localparam int TURN_CYC   = 2;   // ceil(15000/10000)
    localparam int WP_CYC     = 4;   // ceil(35000/10000)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        allow = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [20:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rdy, rvalid, ce_n, we_n, oe_n, dq_oe;
    logic [7:0]  rdata, dq_o, dq_i;
    logic [20:0] maddr;

    int checks = 0;
    int errors = 0;
    int writes_issued = 0;
    int writes_seen = 0;
    bit done = 0;

    typedef struct { int low; int nodrv; } wshape_t;
    logic [7:0] exp_rd_q[$];
    wshape_t    exp_wr_q[$];
    logic [7:0] shadow[int unsigned];
    logic [7:0] mem[int unsigned];

    always #(CLK_PERIOD/2) clk = ~clk;

    amem_ctrl #(.CLK_PS(CLK_PS)) uut (
        .clk(clk), .rst_n(rst_n), .allow_i(allow),
        .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
        .host_rdy_o(rdy), .host_rdata_o(rdata), .host_rvalid_o(rvalid),
        .mem_addr_o(maddr), .mem_ce_n_o(ce_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
        .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
    );

    function automatic logic [7:0] dflt(input logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] peek(input logic [20:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return dflt(a);
    endfunction

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
        end
    endtask

    // Memory model: data is valid only in the last cycle of the access window.
    int unsigned acc_cnt = 0;
    logic [20:0] addr_prev = '0;
    always @(posedge clk) begin
        addr_prev <= maddr;
        if (ce_n || oe_n)          acc_cnt <= 0;
        else if (maddr != addr_prev) acc_cnt <= 1;
        else                       acc_cnt <= acc_cnt + 1;
    end
    always_comb begin
        if (!ce_n && !oe_n && we_n && acc_cnt >= ACC_CYC - 1)
            dq_i = mem.exists(int'(maddr)) ? mem[int'(maddr)] : dflt(maddr);
        else
            dq_i = 8'hEE;
    end

    // Monitor
    int  we_low = 0, nodrv = 0;
    bit  clash = 0;
    logic we_prev = 1'b1, oe_prev = 1'b1, dqoe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rvalid) begin
                if (exp_rd_q.size() == 0) check(0, "R3 spurious rvalid", rdata, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rd_q.pop_front();
                    check(rdata == e, "R3/R4 read data", rdata, e);
                end
            end
            if (!we_n) begin
                we_low++;
                if (!dq_oe) nodrv++;
                if (!oe_n || ce_n) clash = 1;
            end
            if (dq_oe && !oe_n) clash = 1;
            if (we_n && !we_prev) begin
                writes_seen++;
                mem[int'(maddr)] = dq_o;
                if (exp_wr_q.size() == 0) check(0, "R2 unexpected write", we_low, 0);
                else begin
                    wshape_t s;
                    s = exp_wr_q.pop_front();
                    check(we_low == s.low, "R7/R8 we-low cycles", we_low, s.low);
                    check(nodrv == s.nodrv, "R7 undriven cycles", nodrv, s.nodrv);
                    check(!ce_n && dq_oe && !clash, "R6/R8/R9 end of write", {ce_n, dq_oe, clash}, 3'b010);
                end
                we_low = 0; nodrv = 0; clash = 0;
            end
            if (!oe_n && oe_prev)
                check(!dqoe_prev && !dq_oe, "R10 drive released before read", {dqoe_prev, dq_oe}, 0);
            we_prev = we_n; oe_prev = oe_n; dqoe_prev = dq_oe;
        end
    end

    task automatic issue(input bit w, input logic [20:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        if (w) begin
            wshape_t s;
            s.low   = oe_n ? WP_CYC : TURN_CYC + WP_CYC;
            s.nodrv = oe_n ? 0 : TURN_CYC;
            exp_wr_q.push_back(s);
            shadow[int'(a)] = d;
            writes_issued++;
        end else begin
            exp_rd_q.push_back(peek(a));
        end
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((exp_rd_q.size() != 0 || exp_wr_q.size() != 0 || !ce_n) && n < 200) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ce_n && we_n && oe_n && !dq_oe && !rvalid, "R1 reset outputs",
              {ce_n, we_n, oe_n, dq_oe, rvalid}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ce_n && we_n && oe_n && !dq_oe && rdy, "R1 after reset", {ce_n, we_n, oe_n, dq_oe, rdy}, 5'b11101);

        issue(0, 21'h1ABCD, 0);                 // R3 unwritten location
        wait_idle();
        issue(1, 21'h000010, 8'hA5);            // R7 write from deselect
        wait_idle();
        issue(0, 21'h000010, 0);                // R3 read back
        issue(1, 21'h1FFFFF, 8'h3C);            // R7 write right after read
        wait_idle();
        issue(0, 21'h1FFFFF, 0);                // R5 back-to-back reads
        issue(0, 21'h000010, 0);
        issue(0, 21'h000000, 0);
        wait_idle();

        // R2 ignored while access withheld
        allow = 1'b0;
        @(negedge clk);
        check(!rdy, "R2 ready with allow low", rdy, 0);
        req = 1'b1; we = 1'b1; addr = 21'h000010; wdata = 8'hFF;
        repeat (6) @(negedge clk);
        check(we_n && ce_n && !rdy, "R2 no write while withheld", {we_n, ce_n, rdy}, 3'b110);
        req = 1'b0;
        allow = 1'b1;
        issue(0, 21'h000010, 0);
        wait_idle();

        // R2 request during a busy read is ignored
        issue(0, 21'h000020, 0);
        req = 1'b1; we = 1'b1; addr = 21'h000020; wdata = 8'h77;
        @(negedge clk);
        check(!rdy, "R2 busy ready", rdy, 0);
        req = 1'b0;
        wait_idle();
        issue(0, 21'h000020, 0);
        wait_idle();

        // R11 allow drops during a read
        issue(0, 21'h0ABCDE, 0);
        allow = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(ce_n && oe_n && !rdy, "R11 deselect after withdraw", {ce_n, oe_n, rdy}, 3'b110);
        allow = 1'b1;
        repeat (2) @(negedge clk);

        check(writes_seen == writes_issued, "R2 write count", writes_seen, writes_issued);
        check(exp_rd_q.size() == 0, "R3 pending reads", exp_rd_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule